// File: doc/BRIEF.md
# Prior-Result Branch Condition Tracker

This block keeps the branch state of a small 16-bit register machine. The state is not a set of stored flags. It is a pointer to whichever register produced the most recent result, plus one carry bit. A register update event names an opcode class, a register and the carry out of the arithmetic unit. The block decides which register becomes the result register and whether the carry survives. It applies the new state on the next clock edge. A subroutine-call event forces the accumulator to be the result register and clears the carry.

The recorded register index leaves on `rd_idx`, so the surrounding register file can return that register's live contents on `rd_data`. A 4-bit branch code is evaluated combinationally against `rd_data` and the carry, and the block drives a take decision. The state is also exposed as a packed status byte. That byte holds the register index times two, with the carry in bit 0.

The update and call inputs are single-cycle strobes with no back-pressure, because the block always accepts an update in the cycle it arrives. All other pins are plain level signals.

Top module: `prior_result_tracker`

## Requirements
- R1: After reset, `status` is 0x00 and `rd_idx` is 0, meaning the accumulator R0 is the result register and the carry is clear.
- R2: An update with `upd_op` equal to 1 through 9, C, E or F records `upd_reg` as the result register and clears the carry, whatever `alu_carry` is. The new state is visible one clock after the strobe.
- R3: An update with `upd_op` A (add) or B (subtract) records register 0 and stores `alu_carry` as the carry.
- R4: An update with `upd_op` D (compare) records register 13 and stores `alu_carry` as the carry.
- R5: `status` equals the result index times two plus the carry bit, and bits 7 to 5 are zero. `rd_idx` always equals status bits 4 to 1.
- R6: Branch code 1 always takes. Code 2 takes when the carry is clear, and code 3 takes when the carry is set.
- R7: Code 4 takes when bit 15 of `rd_data` is 0, and code 5 takes when it is 1.
- R8: Code 6 takes when `rd_data` is 0x0000, and code 7 takes when it is not.
- R9: Code 8 takes when `rd_data` is 0xFFFF, and code 9 takes when it is not.
- R10: Codes 0, A, B, D, E and F never take. Code C (subroutine call) always takes.
- R11: With neither strobe asserted, or with `upd_valid` asserted and `upd_op` equal to 0, the state does not change.
- R12: `bs_evt` records register 0 with the carry clear on the next clock. It has priority over a simultaneous `upd_valid`.
- R13: `take` follows `rd_data` and `br_code` within the same cycle, with no clock in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Register-operation update strobe |
| upd_op | input | 4 | Opcode class (high nibble) of the operation |
| upd_reg | input | 4 | Register named by the operation |
| alu_carry | input | 1 | Carry out from the arithmetic unit |
| bs_evt | input | 1 | Subroutine-call strobe |
| rd_data | input | 16 | Live contents of register `rd_idx` |
| br_code | input | 4 | Branch code to evaluate |
| rd_idx | output | 4 | Recorded result register index |
| status | output | 8 | Packed status byte |
| take | output | 1 | Branch decision |

## Verification
The bench aims first at the redirected destinations, because a design that records the named register for add, subtract or compare would point branches at the wrong data. It also checks that carry is masked on every non-arithmetic operation, since a leak there would make codes 2 and 3 follow stale carries. It tests the boundary values 0x0000, 0x7FFF, 0x8000 and 0xFFFF, where a tracker that mixes up the sign and minus-one tests, or that stores flags instead of reading live data, gives the wrong decision. Finally, it checks the opcode-0 update and the priority of the call strobe, where a sloppy decoder would corrupt the state.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int DATA_W = 16;
  localparam int IDX_W  = 4;
  localparam int STAT_W = 8;

  typedef enum logic [3:0] {
    OPC_NONE = 4'h0,
    OPC_ADD  = 4'hA,
    OPC_SUB  = 4'hB,
    OPC_CMP  = 4'hD
  } op_class_e;

  typedef enum logic [3:0] {
    BRC_EXIT    = 4'h0,
    BRC_ALWAYS  = 4'h1,
    BRC_NOCARRY = 4'h2,
    BRC_CARRY   = 4'h3,
    BRC_PLUS    = 4'h4,
    BRC_MINUS   = 4'h5,
    BRC_ZERO    = 4'h6,
    BRC_NZERO   = 4'h7,
    BRC_M1      = 4'h8,
    BRC_NM1     = 4'h9,
    BRC_BREAK   = 4'hA,
    BRC_RETSUB  = 4'hB,
    BRC_CALL    = 4'hC
  } br_code_e;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             carry;
  } trk_state_t;
endpackage

// File: rtl/prt_upd_decode.sv
module prt_upd_decode
  import prt_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter logic [IW-1:0] ACC_REG = '0,
  parameter logic [IW-1:0] CMP_REG = IW'(13)
) (
  input  logic          upd_valid,
  input  logic [3:0]    upd_op,
  input  logic [IW-1:0] upd_reg,
  input  logic          alu_carry,
  input  logic          bs_evt,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          wr_carry
);
  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = ACC_REG;
    wr_carry = 1'b0;
    if (bs_evt) begin
      wr_en = 1'b1;
    end else if (upd_valid && upd_op != OPC_NONE) begin
      wr_en = 1'b1;
      case (upd_op)
        OPC_ADD, OPC_SUB: begin
          wr_idx   = ACC_REG;
          wr_carry = alu_carry;
        end
        OPC_CMP: begin
          wr_idx   = CMP_REG;
          wr_carry = alu_carry;
        end
        default: begin
          wr_idx   = upd_reg;
          wr_carry = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/prt_state_reg.sv
module prt_state_reg
  import prt_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic          wr_carry,
  output logic [IW-1:0] idx,
  output logic          carry
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      carry <= 1'b0;
    end else if (wr_en) begin
      idx   <= wr_idx;
      carry <= wr_carry;
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx == $past(wr_idx)) && (carry == $past(wr_carry)));
endmodule

// File: rtl/prt_cond_eval.sv
module prt_cond_eval
  import prt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [3:0]    code,
  input  logic          carry,
  input  logic [DW-1:0] value,
  output logic          take
);
  logic is_zero, is_m1, is_neg;

  assign is_zero = (value == '0);
  assign is_m1   = (value == '1);
  assign is_neg  = value[DW-1];

  always_comb begin
    case (code)
      BRC_ALWAYS:  take = 1'b1;
      BRC_CALL:    take = 1'b1;
      BRC_NOCARRY: take = !carry;
      BRC_CARRY:   take = carry;
      BRC_PLUS:    take = !is_neg;
      BRC_MINUS:   take = is_neg;
      BRC_ZERO:    take = is_zero;
      BRC_NZERO:   take = !is_zero;
      BRC_M1:      take = is_m1;
      BRC_NM1:     take = !is_m1;
      default:     take = 1'b0;
    endcase
  end

  // R9: minus one implies minus, so it can never take on plus
  always_comb begin
    if (code == BRC_M1 && take) p_m1_is_neg_r9: assert (is_neg);
  end
endmodule

// File: rtl/prior_result_tracker.sv
module prior_result_tracker
  import prt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [3:0]        upd_op,
  input  logic [IDX_W-1:0]  upd_reg,
  input  logic              alu_carry,
  input  logic              bs_evt,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [3:0]        br_code,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [STAT_W-1:0] status,
  output logic              take
);
  localparam logic [IDX_W-1:0] ACC_REG = '0;
  localparam logic [IDX_W-1:0] CMP_REG = IDX_W'(13);

  logic             wr_en, wr_carry;
  logic [IDX_W-1:0] wr_idx;
  trk_state_t       st;

  prt_upd_decode #(.IW(IDX_W), .ACC_REG(ACC_REG), .CMP_REG(CMP_REG)) u_dec (
    .upd_valid(upd_valid), .upd_op(upd_op), .upd_reg(upd_reg),
    .alu_carry(alu_carry), .bs_evt(bs_evt),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_carry(wr_carry)
  );

  prt_state_reg #(.IW(IDX_W)) u_st (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_carry(wr_carry), .idx(st.idx), .carry(st.carry)
  );

  prt_cond_eval #(.DW(DATA_W)) u_eval (
    .code(br_code), .carry(st.carry), .value(rd_data), .take(take)
  );

  assign rd_idx = st.idx;
  assign status = STAT_W'(st);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!bs_evt && !(upd_valid && upd_op != OPC_NONE)) |=> $stable(status));

  p_cmp_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_op == OPC_CMP && !bs_evt) |=> rd_idx == CMP_REG);

  p_call_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bs_evt |=> status == '0);

  p_plain_op_no_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !bs_evt && upd_op != OPC_NONE && upd_op != OPC_ADD &&
     upd_op != OPC_SUB && upd_op != OPC_CMP) |=> !status[0]);

  always_comb begin
    if (rst_n) p_pad_zero_r5: assert (status[STAT_W-1:IDX_W+1] == '0);
  end
endmodule

// File: tb/prior_result_tracker_test.sv
module prior_result_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0, alu_carry = 1'b0, bs_evt = 1'b0;
  logic [3:0] upd_op = '0, upd_reg = '0, br_code = '0;
  logic [15:0] rd_data = '0;
  logic [3:0] rd_idx;
  logic [7:0] status;
  logic take;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  prior_result_tracker uut (.*);

  // {op, reg, carry, expected status}
  localparam logic [16:0] VEC [8] = '{
    {4'h2, 4'h5, 1'b1, 8'h0A},
    {4'hA, 4'h7, 1'b1, 8'h01},
    {4'hB, 4'h3, 1'b0, 8'h00},
    {4'hD, 4'h6, 1'b1, 8'h1B},
    {4'hD, 4'h6, 1'b0, 8'h1A},
    {4'hF, 4'hF, 1'b1, 8'h1E},
    {4'h1, 4'hE, 1'b0, 8'h1C},
    {4'hC, 4'h9, 1'b1, 8'h12}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [3:0] op, input logic [3:0] rg, input logic cy, input logic bs);
    @(negedge clk);
    upd_valid = 1'b1; upd_op = op; upd_reg = rg; alu_carry = cy; bs_evt = bs;
    @(negedge clk);
    upd_valid = 1'b0; bs_evt = 1'b0;
  endtask

  task automatic br(input string req, input logic [3:0] c, input logic [15:0] d, input logic exp);
    br_code = c; rd_data = d;
    #1;
    chk(req, {7'd0, take}, {7'd0, exp});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 rd_idx", {4'h0, rd_idx}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      upd(VEC[i][16:13], VEC[i][12:9], VEC[i][8], 1'b0);
      chk("R2/R3/R4/R5 table", status, VEC[i][7:0]);
      chk("R5 rd_idx", {4'h0, rd_idx}, {4'h0, VEC[i][4:1]});
    end

    // R11: opcode 0 update and idle cycles leave the state
    upd(4'h0, 4'h3, 1'b1, 1'b0);
    chk("R11 op0 ignored", status, 8'h12);
    repeat (3) @(negedge clk);
    chk("R11 idle hold", status, 8'h12);

    // R12: call event wins over a compare update
    upd(4'hD, 4'h2, 1'b1, 1'b1);
    chk("R12 call priority", status, 8'h00);

    // R6: carry branches, carry set via add
    upd(4'hA, 4'h4, 1'b1, 1'b0);
    br("R6 code1", 4'h1, 16'h1234, 1'b1);
    br("R6 code2 carry set", 4'h2, 16'h0, 1'b0);
    br("R6 code3 carry set", 4'h3, 16'h0, 1'b1);
    upd(4'h5, 4'h4, 1'b1, 1'b0);
    br("R6 code2 carry clear", 4'h2, 16'h0, 1'b1);
    br("R6 code3 carry clear", 4'h3, 16'h0, 1'b0);

    // R7/R8/R9 boundary values
    br("R7 plus 7FFF", 4'h4, 16'h7FFF, 1'b1);
    br("R7 plus 8000", 4'h4, 16'h8000, 1'b0);
    br("R7 minus 8000", 4'h5, 16'h8000, 1'b1);
    br("R7 minus 0000", 4'h5, 16'h0000, 1'b0);
    br("R8 zero 0000", 4'h6, 16'h0000, 1'b1);
    br("R8 zero 0001", 4'h6, 16'h0001, 1'b0);
    br("R8 nzero 8000", 4'h7, 16'h8000, 1'b1);
    br("R8 nzero 0000", 4'h7, 16'h0000, 1'b0);
    br("R9 m1 FFFF", 4'h8, 16'hFFFF, 1'b1);
    br("R9 m1 FFFE", 4'h8, 16'hFFFE, 1'b0);
    br("R9 nm1 FFFF", 4'h9, 16'hFFFF, 1'b0);
    br("R9 nm1 7FFF", 4'h9, 16'h7FFF, 1'b1);

    // R10: codes that never take, and the call code
    br("R10 code0", 4'h0, 16'hFFFF, 1'b0);
    br("R10 codeA", 4'hA, 16'h0000, 1'b0);
    br("R10 codeB", 4'hB, 16'h0000, 1'b0);
    br("R10 codeD", 4'hD, 16'h0000, 1'b0);
    br("R10 codeF", 4'hF, 16'hFFFF, 1'b0);
    br("R10 codeC", 4'hC, 16'h0000, 1'b1);

    // R13: live data change flips the decision with no clock edge
    br("R13 live before", 4'h6, 16'h0000, 1'b1);
    br("R13 live after", 4'h6, 16'h0040, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule